// File: doc/BRIEF.md
# Scatter-Gather Write Burst Scheduler

This block takes a stream of 256-bit data beats from user logic and turns it into memory write bursts that land in a list of destination regions. Software loads a table of entries through a small word-addressed register port. Each entry holds a bus address, a length in beats and two flags: valid and last-of-list. Destinations may be host memory or device memory. Both are plain bus addresses to this block. After the run bit is set, the scheduler takes entries in index order with no further software action. For each entry it issues burst requests (address plus beat count) to a downstream packetizer, then passes the payload beats through with handshaking on both sides.

Every burst is limited by a programmable size and never crosses a 4 KB page. When an entry is filled, its valid flag is cleared so software can reuse the slot. A last-of-list entry raises a done flag. The engine then halts, or returns to slot 0 when wrap is enabled, which supports ping-pong buffering. An entry that is not valid parks the engine with a stall flag until software arms it. Byte counters for the current entry and for the whole run can be read back.

Top module: `sgw_scheduler`

## Requirements
- R1: After reset, STATUS (word 0x01) reads 0, both total counter words read 0, and req_valid, wr_valid and in_ready are low.
- R2: The table entry for slot i sits at word 0x40+4*i, with these fields: +0 address bits [31:0], +1 address bits [63:32], +2 length in 32-byte beats, +3 flags (bit0 valid, bit1 last). Address bits [4:0] are stored as zero. A length above 0x0400_0000 beats (2 GB) is stored as 0x0400_0000.
- R3: Each burst carries between 1 and 2^code beats, where code is CTRL (word 0x00) bits [4:2]. CTRL bit0 is run and bit1 is wrap.
- R4: No burst crosses a 4096-byte address boundary.
- R5: Entries are served in index order. Each entry's bursts cover its region contiguously from its start address. A filled entry has its valid flag cleared.
- R6: Reaching an entry whose valid flag is clear sets STATUS bit1 (stalled) and issues no request. Service resumes once the entry is armed.
- R7: Filling an entry flagged last sets STATUS bit0 (done). Without wrap the engine then halts (STATUS bit2 busy = 0) until CTRL is written. Any CTRL write clears done.
- R8: With wrap set, the slot after a last entry is slot 0. STATUS bits [15:8] give the current slot.
- R9: With run clear, no new entry is started. An entry already in progress completes.
- R10: An armed zero-length entry is consumed without any burst.
- R11: ENTRY_BYTES (word 0x04) counts bytes written into the current entry and restarts at 0 when an entry is loaded. TOTAL (words 0x02 low, 0x03 high) counts all bytes written since reset.
- R12: Payload beats leave in arrival order with no loss or duplication under backpressure on any side. wr_last marks the final beat of each burst. A request holds its address and beat count until it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| in_valid | input | 1 | User beat available |
| in_ready | output | 1 | User beat taken |
| in_data | input | 256 | User beat |
| req_valid | output | 1 | Burst request valid |
| req_ready | input | 1 | Burst request accepted |
| req_addr | output | 64 | Burst start bus address |
| req_beats | output | 8 | Burst length in beats |
| wr_valid | output | 1 | Payload beat valid |
| wr_ready | input | 1 | Payload beat accepted |
| wr_data | output | 256 | Payload beat |
| wr_last | output | 1 | Final beat of burst |

## Verification
A wrong slot index or a lost remaining-length count shows at the request port on the very next burst: the address or beat count differs from what the bench derives from the table. A bad page or size calculation shows the same way, on the first burst that reaches a boundary. A corrupted beat counter shows as a misplaced wr_last, or as a data sequence number that skips or repeats, on the beat where it goes wrong. Stale flag or counter state surfaces in the next STATUS or ENTRY_BYTES read, which the bench takes at fixed points in each scenario.

// File: rtl/sgw_pkg.sv
package sgw_pkg;
  localparam int BEAT_BYTES    = 32;
  localparam int BEAT_SHIFT    = $clog2(BEAT_BYTES);
  localparam int DATA_W        = BEAT_BYTES * 8;
  localparam int ADDR_W        = 64;
  localparam int PAGE_BYTES    = 4096;
  localparam int PAGE_BEATS    = PAGE_BYTES / BEAT_BYTES;
  localparam int PAGE_OFF_W    = $clog2(PAGE_BEATS);
  localparam int LEN_W         = 27;
  localparam int MAX_LEN_BEATS = 1 << 26;
  localparam int BURST_W       = PAGE_OFF_W + 1;
  localparam int CODE_W        = 3;
  localparam int REG_AW        = 8;
  localparam int REG_DW        = 32;

  localparam logic [REG_AW-1:0] RA_CTRL   = 8'h00;
  localparam logic [REG_AW-1:0] RA_STATUS = 8'h01;
  localparam logic [REG_AW-1:0] RA_TOT_LO = 8'h02;
  localparam logic [REG_AW-1:0] RA_TOT_HI = 8'h03;
  localparam logic [REG_AW-1:0] RA_ENTRY  = 8'h04;
  localparam logic [REG_AW-1:0] RA_TABLE  = 8'h40;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_REQ, ST_DATA, ST_FINISH, ST_HALT
  } eng_state_t;

  // Beats in the next burst: smallest of what is left, the size cap and
  // the distance to the next page boundary.
  function automatic logic [BURST_W-1:0] burst_beats(
      input logic [PAGE_OFF_W-1:0] page_off,
      input logic [LEN_W-1:0]      remaining,
      input logic [CODE_W-1:0]     code);
    logic [LEN_W-1:0] cap_size;
    logic [LEN_W-1:0] cap_page;
    logic [LEN_W-1:0] pick;
    cap_size = LEN_W'(1) << code;
    cap_page = LEN_W'(PAGE_BEATS) - LEN_W'(page_off);
    pick = remaining;
    if (cap_size < pick) pick = cap_size;
    if (cap_page < pick) pick = cap_page;
    return pick[BURST_W-1:0];
  endfunction

  // Length written by software, clamped to the 2 GB region limit.
  function automatic logic [LEN_W-1:0] clamp_len(input logic [REG_DW-1:0] w);
    if (w > REG_DW'(MAX_LEN_BEATS)) return LEN_W'(MAX_LEN_BEATS);
    return w[LEN_W-1:0];
  endfunction
endpackage

// File: rtl/sgw_regfile.sv
module sgw_regfile
  import sgw_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic [REG_AW-1:0]    reg_addr,
  input  logic [REG_DW-1:0]    reg_wdata,
  output logic [REG_DW-1:0]    reg_rdata,
  output logic                 ctrl_run,
  output logic                 ctrl_wrap,
  output logic [CODE_W-1:0]    ctrl_code,
  output logic                 ctrl_upd,
  input  logic [IDX_W-1:0]     sel_idx,
  output logic [ADDR_W-1:0]    ent_addr,
  output logic [LEN_W-1:0]     ent_len,
  output logic                 ent_valid,
  output logic                 ent_last,
  input  logic                 consume,
  input  logic                 st_done,
  input  logic                 st_stalled,
  input  logic                 st_busy,
  input  logic [31:0]          st_entry_bytes,
  input  logic [63:0]          st_total_bytes
);
  localparam int TBL_WORDS = NUM_ENTRIES * 4;

  logic [ADDR_W-1:0] tbl_addr  [NUM_ENTRIES];
  logic [LEN_W-1:0]  tbl_len   [NUM_ENTRIES];
  logic              tbl_valid [NUM_ENTRIES];
  logic              tbl_last  [NUM_ENTRIES];

  logic [REG_AW-1:0] tbl_off;
  logic              tbl_hit;
  logic [IDX_W-1:0]  tbl_idx;
  logic [1:0]        tbl_fld;
  logic              tbl_we;

  assign tbl_off = reg_addr - RA_TABLE;
  assign tbl_hit = (reg_addr >= RA_TABLE) && (32'(tbl_off) < 32'(TBL_WORDS));
  assign tbl_idx = tbl_off[IDX_W+1:2];
  assign tbl_fld = tbl_off[1:0];
  assign tbl_we  = reg_wr && tbl_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_run  <= 1'b0;
      ctrl_wrap <= 1'b0;
      ctrl_code <= '0;
      ctrl_upd  <= 1'b0;
    end else begin
      ctrl_upd <= reg_wr && (reg_addr == RA_CTRL);
      if (reg_wr && (reg_addr == RA_CTRL)) begin
        ctrl_run  <= reg_wdata[0];
        ctrl_wrap <= reg_wdata[1];
        ctrl_code <= reg_wdata[4:2];
      end
    end
  end

  // Table storage: engine consumption clears valid, a software write to the
  // same flags word in the same cycle overrides it.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        tbl_addr[i]  <= '0;
        tbl_len[i]   <= '0;
        tbl_valid[i] <= 1'b0;
        tbl_last[i]  <= 1'b0;
      end
    end else begin
      for (int i = 0; i < NUM_ENTRIES; i++) begin
        if (consume && (sel_idx == IDX_W'(i))) tbl_valid[i] <= 1'b0;
        if (tbl_we && (tbl_idx == IDX_W'(i))) begin
          case (tbl_fld)
            2'd0: tbl_addr[i][31:0]  <= {reg_wdata[31:BEAT_SHIFT], {BEAT_SHIFT{1'b0}}};
            2'd1: tbl_addr[i][63:32] <= reg_wdata;
            2'd2: tbl_len[i]         <= clamp_len(reg_wdata);
            default: begin
              tbl_valid[i] <= reg_wdata[0];
              tbl_last[i]  <= reg_wdata[1];
            end
          endcase
        end
      end
    end
  end

  assign ent_addr  = tbl_addr[sel_idx];
  assign ent_len   = tbl_len[sel_idx];
  assign ent_valid = tbl_valid[sel_idx];
  assign ent_last  = tbl_last[sel_idx];

  always_comb begin
    reg_rdata = '0;
    if (tbl_hit) begin
      case (tbl_fld)
        2'd0:    reg_rdata = tbl_addr[tbl_idx][31:0];
        2'd1:    reg_rdata = tbl_addr[tbl_idx][63:32];
        2'd2:    reg_rdata = REG_DW'(tbl_len[tbl_idx]);
        default: reg_rdata = {30'd0, tbl_last[tbl_idx], tbl_valid[tbl_idx]};
      endcase
    end else begin
      case (reg_addr)
        RA_CTRL:   reg_rdata = {27'd0, ctrl_code, ctrl_wrap, ctrl_run};
        RA_STATUS: reg_rdata = {16'd0, 8'(sel_idx), 5'd0, st_busy, st_stalled, st_done};
        RA_TOT_LO: reg_rdata = st_total_bytes[31:0];
        RA_TOT_HI: reg_rdata = st_total_bytes[63:32];
        RA_ENTRY:  reg_rdata = st_entry_bytes;
        default:   reg_rdata = '0;
      endcase
    end
  end

  // A consumed slot reads back as not valid unless software re-armed it
  AST_CONSUME_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    consume && !tbl_we |=> !tbl_valid[$past(sel_idx)]) else $error("consume"); // R5
endmodule

// File: rtl/sgw_engine.sv
module sgw_engine
  import sgw_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  parameter int IDX_W       = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctrl_run,
  input  logic                 ctrl_wrap,
  input  logic [CODE_W-1:0]    ctrl_code,
  input  logic                 ctrl_upd,
  input  logic [ADDR_W-1:0]    ent_addr,
  input  logic [LEN_W-1:0]     ent_len,
  input  logic                 ent_valid,
  input  logic                 ent_last,
  output logic [IDX_W-1:0]     cur_idx,
  output logic                 consume,
  output logic                 done,
  output logic                 stalled,
  output logic                 busy,
  output logic [31:0]          entry_bytes,
  output logic [63:0]          total_bytes,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [DATA_W-1:0]    in_data,
  output logic                 req_valid,
  input  logic                 req_ready,
  output logic [ADDR_W-1:0]    req_addr,
  output logic [BURST_W-1:0]   req_beats,
  output logic                 wr_valid,
  input  logic                 wr_ready,
  output logic [DATA_W-1:0]    wr_data,
  output logic                 wr_last
);
  eng_state_t         state;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   remaining;
  logic [BURST_W-1:0] beats_left;
  logic [CODE_W-1:0]  cur_code;
  logic               cur_last;

  // Named internal events
  logic req_fire, beat_fire, burst_end, entry_end;
  logic [IDX_W-1:0] next_idx;

  assign req_valid = (state == ST_REQ);
  assign req_addr  = cur_addr;
  assign req_beats = burst_beats(cur_addr[BEAT_SHIFT +: PAGE_OFF_W], remaining, cur_code);
  assign wr_valid  = (state == ST_DATA) && in_valid;
  assign in_ready  = (state == ST_DATA) && wr_ready;
  assign wr_data   = in_data;
  assign wr_last   = (beats_left == BURST_W'(1));

  assign req_fire  = req_valid && req_ready;
  assign beat_fire = wr_valid && wr_ready;
  assign burst_end = beat_fire && (beats_left == BURST_W'(1));
  assign entry_end = (state == ST_FINISH);
  assign consume   = entry_end;
  assign next_idx  = (cur_idx == IDX_W'(NUM_ENTRIES - 1)) ? '0 : cur_idx + 1'b1;

  assign stalled = (state == ST_FETCH) && ctrl_run && !ent_valid;
  assign busy    = (state != ST_IDLE) && (state != ST_HALT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_idx     <= '0;
      cur_addr    <= '0;
      remaining   <= '0;
      beats_left  <= '0;
      cur_code    <= '0;
      cur_last    <= 1'b0;
      done        <= 1'b0;
      entry_bytes <= '0;
      total_bytes <= '0;
    end else begin
      if (ctrl_upd) done <= 1'b0;
      case (state)
        ST_IDLE: if (ctrl_run) state <= ST_FETCH;
        ST_FETCH: begin
          if (!ctrl_run) begin
            state <= ST_IDLE;
          end else if (ent_valid) begin
            cur_addr    <= ent_addr;
            remaining   <= ent_len;
            cur_code    <= ctrl_code;
            cur_last    <= ent_last;
            entry_bytes <= '0;
            state       <= (ent_len == '0) ? ST_FINISH : ST_REQ;
          end
        end
        ST_REQ: if (req_fire) begin
          beats_left <= req_beats;
          state      <= ST_DATA;
        end
        ST_DATA: if (beat_fire) begin
          cur_addr    <= cur_addr + ADDR_W'(BEAT_BYTES);
          remaining   <= remaining - 1'b1;
          beats_left  <= beats_left - 1'b1;
          entry_bytes <= entry_bytes + 32'(BEAT_BYTES);
          total_bytes <= total_bytes + 64'(BEAT_BYTES);
          if (burst_end) state <= (remaining == LEN_W'(1)) ? ST_FINISH : ST_REQ;
        end
        ST_FINISH: begin
          if (cur_last) begin
            done <= 1'b1;
            if (ctrl_wrap) begin
              cur_idx <= '0;
              state   <= ST_FETCH;
            end else begin
              state <= ST_HALT;
            end
          end else begin
            cur_idx <= next_idx;
            state   <= ST_FETCH;
          end
        end
        ST_HALT: if (ctrl_upd) begin
          cur_idx <= '0;
          state   <= ctrl_run ? ST_FETCH : ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BURST_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_beats != '0) && (32'(req_beats) <= (32'd1 << cur_code))) else $error("size"); // R3
  AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (32'(req_addr[BEAT_SHIFT +: PAGE_OFF_W]) + 32'(req_beats)) <= 32'(PAGE_BEATS)) else $error("page"); // R4
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) && $stable(req_beats)) else $error("hold"); // R12
  AST_NO_EMPTY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |-> remaining != '0) else $error("empty"); // R10
  AST_DONE_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    entry_end && cur_last |=> done) else $error("done"); // R7
  AST_TOTAL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_fire |=> total_bytes == $past(total_bytes) + 64'(BEAT_BYTES)) else $error("total"); // R11
  AST_STALL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(stalled) && stalled |-> $stable(cur_idx) && !req_valid) else $error("stall"); // R6
endmodule

// File: rtl/sgw_scheduler.sv
module sgw_scheduler
  import sgw_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [7:0]          reg_addr,
  input  logic [31:0]         reg_wdata,
  output logic [31:0]         reg_rdata,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [255:0]        in_data,
  output logic                req_valid,
  input  logic                req_ready,
  output logic [63:0]         req_addr,
  output logic [7:0]          req_beats,
  output logic                wr_valid,
  input  logic                wr_ready,
  output logic [255:0]        wr_data,
  output logic                wr_last
);
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1;

  logic              ctrl_run, ctrl_wrap, ctrl_upd;
  logic [CODE_W-1:0] ctrl_code;
  logic [IDX_W-1:0]  cur_idx;
  logic [ADDR_W-1:0] ent_addr;
  logic [LEN_W-1:0]  ent_len;
  logic              ent_valid, ent_last, consume;
  logic              st_done, st_stalled, st_busy;
  logic [31:0]       entry_bytes;
  logic [63:0]       total_bytes;

  sgw_regfile #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) regs_i (
    .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .ctrl_run, .ctrl_wrap, .ctrl_code, .ctrl_upd,
    .sel_idx(cur_idx), .ent_addr, .ent_len, .ent_valid, .ent_last,
    .consume, .st_done, .st_stalled, .st_busy,
    .st_entry_bytes(entry_bytes), .st_total_bytes(total_bytes)
  );

  sgw_engine #(.NUM_ENTRIES(NUM_ENTRIES), .IDX_W(IDX_W)) eng_i (
    .clk, .rst_n, .ctrl_run, .ctrl_wrap, .ctrl_code, .ctrl_upd,
    .ent_addr, .ent_len, .ent_valid, .ent_last,
    .cur_idx, .consume, .done(st_done), .stalled(st_stalled), .busy(st_busy),
    .entry_bytes, .total_bytes,
    .in_valid, .in_ready, .in_data,
    .req_valid, .req_ready, .req_addr, .req_beats,
    .wr_valid, .wr_ready, .wr_data, .wr_last
  );
endmodule

// File: tb/sgw_scheduler_tb_top.sv
`timescale 1ns/100ps
module sgw_scheduler_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [255:0] in_data = '0;
  logic req_valid;
  logic req_ready = 1'b0;
  logic [63:0] req_addr;
  logic [7:0] req_beats;
  logic wr_valid;
  logic wr_ready = 1'b0;
  logic [255:0] wr_data;
  logic wr_last;

  always #2.5 clk = ~clk;

  sgw_scheduler dut_i (.*);

  int n_checks = 0, n_fail = 0;
  int budget = -1;
  bit bp = 0;
  int src_seq = 0, mon_seq = 0, mon_left = 0;
  int data_err = 0, last_err = 0;
  int cyc = 0;
  longint exp_total = 0;
  logic [63:0] log_addr[$];
  int log_beats[$];
  logic [63:0] exp_addr[$];
  int exp_beats[$];

  // Producer and sink stimulus
  initial begin
    bit hs;
    forever begin
      @(negedge clk);
      hs = in_valid && in_ready;
      @(posedge clk);
      #1;
      if (hs) begin
        src_seq++;
        if (budget > 0) budget--;
      end
      cyc++;
      in_valid  = (budget != 0) && rst_n && (!bp || (cyc % 3 != 1));
      in_data   = {8{src_seq}};
      wr_ready  = rst_n && (!bp || (cyc % 4 != 2));
      req_ready = rst_n && (!bp || (cyc % 5 != 0));
    end
  end

  // Monitor
  always @(negedge clk) begin
    if (rst_n && req_valid && req_ready) begin
      log_addr.push_back(req_addr);
      log_beats.push_back(int'(req_beats));
      mon_left = int'(req_beats);
    end
    if (rst_n && wr_valid && wr_ready) begin
      if (wr_data !== {8{mon_seq}}) data_err++;
      if (wr_last !== (mon_left == 1)) last_err++;
      mon_seq++;
      mon_left--;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  task automatic set_entry(input int i, input logic [63:0] a, input logic [31:0] len, input logic [1:0] fl);
    wr(8'(8'h40 + 4*i), a[31:0]);
    wr(8'(8'h41 + 4*i), a[63:32]);
    wr(8'(8'h42 + 4*i), len);
    wr(8'(8'h43 + 4*i), {30'd0, fl});
  endtask

  task automatic wait_status(input logic [31:0] want);
    logic [31:0] v;
    for (int k = 0; k < 2000; k++) begin
      rd(8'h01, v);
      if (v == want) break;
    end
  endtask

  // Independent burst split: size cap, then page distance
  task automatic plan(input logic [63:0] a0, input int beats, input int code);
    logic [63:0] a;
    int rem, n, pg;
    a = a0 & ~64'd31;
    rem = beats;
    exp_total += 64'(beats) * 32;
    while (rem > 0) begin
      n = 1 << code;
      pg = (4096 - int'(a % 4096)) / 32;
      if (pg < n) n = pg;
      if (rem < n) n = rem;
      exp_addr.push_back(a);
      exp_beats.push_back(n);
      a += 64'(n) * 32;
      rem -= n;
    end
  endtask

  task automatic clear_logs();
    log_addr.delete(); log_beats.delete();
    exp_addr.delete(); exp_beats.delete();
    data_err = 0; last_err = 0;
  endtask

  task automatic cmp_bursts(input string req);
    check({req, " burst count"}, 64'(log_addr.size()), 64'(exp_addr.size()));
    for (int k = 0; k < exp_addr.size() && k < log_addr.size(); k++) begin
      check({req, " burst addr"}, log_addr[k], exp_addr[k]);
      check({req, " burst beats"}, 64'(log_beats[k]), 64'(exp_beats[k]));
    end
    check("R12 data order", 64'(data_err), 0);
    check("R12 wr_last", 64'(last_err), 0);
    check("R12 no loss", 64'(mon_seq), 64'(src_seq));
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(8'h01, v); check("R1 status", v, 0);
    rd(8'h02, v); check("R1 total lo", v, 0);
    rd(8'h03, v); check("R1 total hi", v, 0);
    check("R1 outputs", {req_valid, wr_valid, in_ready}, 0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    clear_logs();
    set_entry(0, 64'h1_0000_1000, 8, 2'b11);
    plan(64'h1_0000_1000, 8, 1);
    wr(8'h00, 32'h5); // run, code 1
    wait_status(32'h1);
    rd(8'h01, v); check("R7 done halted", v, 32'h1);
    cmp_bursts("R3");
    rd(8'h43, v); check("R5 valid cleared", v, 32'h2);
  endtask

  task automatic t_page();
    logic [31:0] v;
    clear_logs();
    set_entry(0, 64'h2FC7, 6, 2'b11);
    rd(8'h40, v); check("R2 addr low bits", v, 32'h2FC0);
    plan(64'h2FC0, 6, 3);
    wr(8'h00, 32'hD); // run, code 3
    wait_status(32'h1);
    cmp_bursts("R4");
  endtask

  task automatic t_multi_bp();
    logic [31:0] v;
    clear_logs();
    set_entry(0, 64'hA000, 3, 2'b01);
    set_entry(1, 64'hB0E0, 4, 2'b01);
    set_entry(2, 64'hC000, 5, 2'b11);
    plan(64'hA000, 3, 2); plan(64'hB0E0, 4, 2); plan(64'hC000, 5, 2);
    bp = 1;
    wr(8'h00, 32'h9); // run, code 2
    wait_status(32'h201);
    bp = 0;
    rd(8'h01, v); check("R5 ends at slot 2", v, 32'h201);
    cmp_bursts("R5");
  endtask

  task automatic t_stall();
    logic [31:0] v;
    clear_logs();
    wr(8'h00, 32'h5);
    repeat (20) @(posedge clk);
    rd(8'h01, v); check("R6 stalled flag", v, 32'h6);
    check("R6 no request", 64'(log_addr.size()), 0);
    set_entry(0, 64'hD000, 2, 2'b11);
    plan(64'hD000, 2, 1);
    wait_status(32'h1);
    cmp_bursts("R6");
  endtask

  task automatic t_wrap();
    logic [31:0] v;
    clear_logs();
    set_entry(0, 64'hE000, 2, 2'b01);
    set_entry(1, 64'hF000, 3, 2'b11);
    plan(64'hE000, 2, 7); plan(64'hF000, 3, 7);
    wr(8'h00, 32'h1F); // run, wrap, code 7
    wait_status(32'h7);
    rd(8'h01, v); check("R8 back at slot 0", v, 32'h7);
    set_entry(0, 64'h10000, 1, 2'b01);
    plan(64'h10000, 1, 7);
    wait_status(32'h107);
    rd(8'h01, v); check("R8 next slot 1", v, 32'h107);
    cmp_bursts("R8");
  endtask

  task automatic t_run_counts();
    logic [31:0] v;
    clear_logs();
    wr(8'h00, 32'h1C); // run off, code 7
    repeat (3) @(posedge clk);
    rd(8'h01, v); check("R7 done cleared, R9 idle", v, 32'h100);
    set_entry(1, 64'h20000, 6, 2'b11);
    repeat (20) @(posedge clk);
    check("R9 no request while off", 64'(log_addr.size()), 0);
    budget = 3;
    plan(64'h20000, 6, 7);
    wr(8'h00, 32'h1D);
    repeat (40) @(posedge clk);
    rd(8'h04, v); check("R11 entry bytes mid", v, 96);
    rd(8'h01, v); check("R11 busy mid entry", v, 32'h104);
    budget = 3;
    wait_status(32'h101);
    budget = -1;
    rd(8'h04, v); check("R11 entry bytes end", v, 192);
    cmp_bursts("R11");
  endtask

  task automatic t_zero_len();
    logic [31:0] v;
    clear_logs();
    wr(8'h4A, 32'hFFFF_FFFF);
    rd(8'h4A, v); check("R2 length clamp", v, 32'h0400_0000);
    set_entry(0, 64'h0, 0, 2'b01);
    set_entry(1, 64'h30000, 1, 2'b11);
    plan(64'h30000, 1, 7);
    wr(8'h00, 32'h1D);
    wait_status(32'h101);
    cmp_bursts("R10");
    rd(8'h43, v); check("R10 zero entry consumed", v, 0);
    rd(8'h02, v); check("R11 total lo", v, exp_total[31:0]);
    rd(8'h03, v); check("R11 total hi", v, exp_total[63:32]);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    t_reset();
    t_basic();
    t_page();
    t_multi_bp();
    t_stall();
    t_wrap();
    t_run_counts();
    t_zero_len();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R1 actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule